// File: doc/BRIEF.md
# Data-Space Mapped Register File

This block is the 8-bit working register file of a small RISC core. It holds 32 registers. Two combinational read ports and one ALU write port let one ALU operation finish each cycle. Six of the registers also act as three 16-bit address pointers. The pointers are driven out of the block. A dedicated pointer-write port replaces both bytes of one pointer at a single clock edge, which serves post-increment and pre-decrement addressing. The third pointer also drives the program-memory table-lookup address.

The same registers sit at the bottom of the data address space. A load/store request port uses valid/ready. It decodes each address and sends the access to one of three places:
- the register file itself, which is always ready;
- a 64-location I/O bus, which takes the I/O offset and passes back its own ready;
- an external data SRAM bus, which gets the full address, separate read and write strobes, and passes back its own ready.

A request transfers in the cycle where both `ds_valid` and `ds_ready` are high. A write lands at that clock edge. Read data is combinational in the same cycle. The requester must hold its request stable while `ds_ready` is low. The external buses see their strobes for as long as the request is pending.

Top module: `rf_dspace_top`

## Requirements
- R1: After reset, every one of the 32 registers reads 0 on both read ports, and all three pointer outputs and `pm_addr` are 0.
- R2: Read ports `ra_data`/`rb_data` return the value the register held before the current clock edge. A write to the same register in the same cycle becomes visible only after that edge.
- R3: When `alu_we` is high, `alu_wdata` is stored into register `alu_widx` at the clock edge.
- R4: `x_ptr` is {reg27, reg26}, `y_ptr` is {reg29, reg28` and `z_ptr` is {reg31, reg30}, each with the low byte in the even register. `pm_addr` always equals `z_ptr`.
- R5: When `ptr_we` is high, `ptr_sel` picks the pointer (0 = X, 1 = Y, 2 = Z, 3 = none). `ptr_wdata` replaces both bytes of the chosen pointer at one edge. With `ptr_sel` = 3, no register changes.
- R6: If the pointer-write port and the ALU write port target the same register in one cycle, the pointer-write value is stored.
- R7: A data-space address below 0x20 accesses register (address) with `ds_ready` = 1. A read returns the register value on `ds_rdata` in the same cycle, and a write is stored at the edge. A data-space register write and an ALU write must never be asserted in the same cycle.
- R8: Addresses 0x20 to 0x5F go to the I/O bus with `io_addr` = address − 0x20. `io_valid` and `io_we` follow the request, `ds_ready` equals `io_ready`, and `ds_rdata` equals `io_rdata`.
- R9: Addresses 0x60 and above go to the SRAM bus with the address unchanged. `sram_rd` is high for a read and `sram_wr` for a write, never both. `ds_ready` equals `sram_ready`, and `ds_rdata` equals `sram_rdata`.
- R10: At most one target is strobed per cycle. With `ds_valid` low, neither the I/O strobe nor the SRAM strobes are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_idx | input | 5 | Read port A register index |
| ra_data | output | 8 | Read port A data |
| rb_idx | input | 5 | Read port B register index |
| rb_data | output | 8 | Read port B data |
| alu_we | input | 1 | ALU write enable |
| alu_widx | input | 5 | ALU write register index |
| alu_wdata | input | 8 | ALU write data |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | New 16-bit pointer value |
| x_ptr | output | 16 | X pointer |
| y_ptr | output | 16 | Y pointer |
| z_ptr | output | 16 | Z pointer |
| pm_addr | output | 16 | Program-memory lookup address (Z) |
| ds_valid | input | 1 | Data-space request valid |
| ds_ready | output | 1 | Data-space request accepted |
| ds_we | input | 1 | Data-space request is a write |
| ds_addr | input | 16 | Data-space address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| io_valid | output | 1 | I/O bus request strobe |
| io_ready | input | 1 | I/O bus accepts request |
| io_we | output | 1 | I/O bus write |
| io_addr | output | 6 | I/O bus address |
| io_wdata | output | 8 | I/O bus write data |
| io_rdata | input | 8 | I/O bus read data |
| sram_rd | output | 1 | SRAM read strobe |
| sram_wr | output | 1 | SRAM write strobe |
| sram_ready | input | 1 | SRAM accepts request |
| sram_addr | output | 16 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |

## Verification
A corrupted register or a wrong write priority shows at the pointer outputs within one cycle of the write. For the other registers, it shows on the next cycle that any read port or a data-space read selects that index. A decode fault shows at once in the same cycle: the wrong strobe is raised, the I/O offset is wrong, or `ds_ready` follows the wrong bus. The bench therefore reads every written value back through a second path, either a read port, a pointer output or a data-space read. Its address cases sit on both sides of each region boundary.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_NREGS = 32;
  localparam int RF_DW    = 8;
  localparam int RF_IOSZ  = 64;
  localparam int RF_AW    = 16;
  localparam int RF_NPTR  = 3;

  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } psel_e;
endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode #(
  parameter int AW    = rf_pkg::RF_AW,
  parameter int NREGS = rf_pkg::RF_NREGS,
  parameter int IOSZ  = rf_pkg::RF_IOSZ
) (
  input  logic [AW-1:0]           addr,
  output logic                    hit_rf,
  output logic                    hit_io,
  output logic                    hit_sram,
  output logic [$clog2(IOSZ)-1:0] io_off
);
  localparam int IOW       = $clog2(IOSZ);
  localparam int IO_BASE   = NREGS;
  localparam int SRAM_BASE = NREGS + IOSZ;

  logic [AW-1:0] off_full;

  always_comb begin
    hit_rf   = (addr < AW'(IO_BASE));
    hit_sram = (addr >= AW'(SRAM_BASE));
    hit_io   = !hit_rf && !hit_sram;
    off_full = addr - AW'(IO_BASE);
    io_off   = off_full[IOW-1:0];
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NREGS = rf_pkg::RF_NREGS,
  parameter int DW    = rf_pkg::RF_DW,
  parameter int NPTR  = rf_pkg::RF_NPTR
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NREGS)-1:0]     ra_idx,
  output logic [DW-1:0]                ra_data,
  input  logic [$clog2(NREGS)-1:0]     rb_idx,
  output logic [DW-1:0]                rb_data,
  input  logic                         alu_we,
  input  logic [$clog2(NREGS)-1:0]     alu_widx,
  input  logic [DW-1:0]                alu_wdata,
  input  logic                         ds_we,
  input  logic [$clog2(NREGS)-1:0]     ds_idx,
  input  logic [DW-1:0]                ds_wdata,
  output logic [DW-1:0]                ds_rdata,
  input  logic                         ptr_we,
  input  logic [1:0]                   ptr_sel,
  input  logic [2*DW-1:0]              ptr_wdata,
  output logic [NREGS-1:0][DW-1:0]     regs_o
);
  localparam int IDXW  = $clog2(NREGS);
  localparam int PBASE = NREGS - 2*NPTR;

  logic [NREGS-1:0][DW-1:0] regs_q, regs_d;
  logic                     ptr_hit;
  int                       plo;

  always_comb begin
    regs_d  = regs_q;
    ptr_hit = ptr_we && (int'(ptr_sel) < NPTR);
    plo     = PBASE + 2*int'(ptr_sel);
    if (ds_we)  regs_d[ds_idx]   = ds_wdata;
    if (alu_we) regs_d[alu_widx] = alu_wdata;
    if (ptr_hit) begin
      regs_d[plo[IDXW-1:0]]      = ptr_wdata[DW-1:0];
      regs_d[plo[IDXW-1:0] + 1'b1] = ptr_wdata[2*DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign ra_data  = regs_q[ra_idx];
  assign rb_data  = regs_q[rb_idx];
  assign ds_rdata = regs_q[ds_idx];
  assign regs_o   = regs_q;

  // R7
  alu_ds_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_we && ds_we));

  // R3
  alu_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && int'(alu_widx) < PBASE) |=> regs_q[$past(alu_widx)] == $past(alu_wdata));

  // R6
  ptr_over_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd2 && alu_we && int'(alu_widx) == NREGS-2)
      |=> regs_q[NREGS-2] == $past(ptr_wdata[DW-1:0]));
endmodule

// File: rtl/rf_ptr_view.sv
module rf_ptr_view #(
  parameter int NREGS = rf_pkg::RF_NREGS,
  parameter int DW    = rf_pkg::RF_DW,
  parameter int NPTR  = rf_pkg::RF_NPTR
) (
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  output logic [NPTR-1:0][2*DW-1:0] ptrs_o
);
  localparam int PBASE = NREGS - 2*NPTR;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptrs_o[p] = {regs_i[PBASE + 2*p + 1], regs_i[PBASE + 2*p]};
  end
endmodule

// File: rtl/rf_dspace_top.sv
module rf_dspace_top #(
  parameter int NREGS = rf_pkg::RF_NREGS,
  parameter int DW    = rf_pkg::RF_DW,
  parameter int IOSZ  = rf_pkg::RF_IOSZ,
  parameter int AW    = rf_pkg::RF_AW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NREGS)-1:0]  ra_idx,
  output logic [DW-1:0]             ra_data,
  input  logic [$clog2(NREGS)-1:0]  rb_idx,
  output logic [DW-1:0]             rb_data,
  input  logic                      alu_we,
  input  logic [$clog2(NREGS)-1:0]  alu_widx,
  input  logic [DW-1:0]             alu_wdata,
  input  logic                      ptr_we,
  input  logic [1:0]                ptr_sel,
  input  logic [2*DW-1:0]           ptr_wdata,
  output logic [2*DW-1:0]           x_ptr,
  output logic [2*DW-1:0]           y_ptr,
  output logic [2*DW-1:0]           z_ptr,
  output logic [2*DW-1:0]           pm_addr,
  input  logic                      ds_valid,
  output logic                      ds_ready,
  input  logic                      ds_we,
  input  logic [AW-1:0]             ds_addr,
  input  logic [DW-1:0]             ds_wdata,
  output logic [DW-1:0]             ds_rdata,
  output logic                      io_valid,
  input  logic                      io_ready,
  output logic                      io_we,
  output logic [$clog2(IOSZ)-1:0]   io_addr,
  output logic [DW-1:0]             io_wdata,
  input  logic [DW-1:0]             io_rdata,
  output logic                      sram_rd,
  output logic                      sram_wr,
  input  logic                      sram_ready,
  output logic [AW-1:0]             sram_addr,
  output logic [DW-1:0]             sram_wdata,
  input  logic [DW-1:0]             sram_rdata
);
  localparam int IDXW = $clog2(NREGS);
  localparam int IOW  = $clog2(IOSZ);
  localparam int NPTR = rf_pkg::RF_NPTR;

  logic                       hit_rf, hit_io, hit_sram;
  logic [IOW-1:0]             io_off;
  logic                       rf_ds_we;
  logic [DW-1:0]              rf_ds_rdata;
  logic [NREGS-1:0][DW-1:0]   regs;
  logic [NPTR-1:0][2*DW-1:0]  ptrs;

  rf_addr_decode #(.AW(AW), .NREGS(NREGS), .IOSZ(IOSZ)) u_dec (
    .addr(ds_addr), .hit_rf(hit_rf), .hit_io(hit_io),
    .hit_sram(hit_sram), .io_off(io_off)
  );

  assign rf_ds_we = ds_valid && ds_we && hit_rf;

  rf_storage #(.NREGS(NREGS), .DW(DW), .NPTR(NPTR)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
    .ds_we(rf_ds_we), .ds_idx(ds_addr[IDXW-1:0]), .ds_wdata(ds_wdata),
    .ds_rdata(rf_ds_rdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .regs_o(regs)
  );

  rf_ptr_view #(.NREGS(NREGS), .DW(DW), .NPTR(NPTR)) u_ptr (
    .regs_i(regs), .ptrs_o(ptrs)
  );

  assign x_ptr   = ptrs[0];
  assign y_ptr   = ptrs[1];
  assign z_ptr   = ptrs[2];
  assign pm_addr = ptrs[2];

  always_comb begin
    io_valid   = ds_valid && hit_io;
    io_we      = ds_we;
    io_addr    = io_off;
    io_wdata   = ds_wdata;
    sram_rd    = ds_valid && hit_sram && !ds_we;
    sram_wr    = ds_valid && hit_sram && ds_we;
    sram_addr  = ds_addr;
    sram_wdata = ds_wdata;
    if (hit_io) begin
      ds_ready = io_ready;
      ds_rdata = io_rdata;
    end else if (hit_sram) begin
      ds_ready = sram_ready;
      ds_rdata = sram_rdata;
    end else begin
      ds_ready = 1'b1;
      ds_rdata = rf_ds_rdata;
    end
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_valid, sram_rd || sram_wr, rf_ds_we}) && !(sram_rd && sram_wr));

  // R8
  io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |-> (ds_addr >= AW'(NREGS) && ds_addr < AW'(NREGS + IOSZ)));

  // R5
  ptr_x_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd0) |=> x_ptr == $past(ptr_wdata));
endmodule

// File: tb/rf_dspace_top_tb.sv
module rf_dspace_top_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra_idx = 0, rb_idx = 0, alu_widx = 0;
  logic [7:0] ra_data, rb_data, alu_wdata = 0;
  logic alu_we = 0, ptr_we = 0;
  logic [1:0] ptr_sel = 0;
  logic [15:0] ptr_wdata = 0, x_ptr, y_ptr, z_ptr, pm_addr;
  logic ds_valid = 0, ds_ready, ds_we = 0;
  logic [15:0] ds_addr = 0;
  logic [7:0] ds_wdata = 0, ds_rdata;
  logic io_valid, io_ready = 1, io_we;
  logic [5:0] io_addr;
  logic [7:0] io_wdata, io_rdata = 0;
  logic sram_rd, sram_wr, sram_ready = 1;
  logic [15:0] sram_addr;
  logic [7:0] sram_wdata, sram_rdata = 0;

  int errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  rf_dspace_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr), .pm_addr(pm_addr),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_we(ds_we), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sram_rd(sram_rd), .sram_wr(sram_wr), .sram_ready(sram_ready),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Hold the current inputs through one rising edge, then release strobes.
  task automatic step();
    @(posedge clk);
    #1;
    alu_we = 0; ptr_we = 0; ds_valid = 0; ds_we = 0;
    #1;
  endtask

  task automatic t_reset();
    logic bad = 0;
    for (int i = 0; i < 32; i++) begin
      ra_idx = 5'(i); rb_idx = 5'(31 - i); #1;
      if (ra_data !== 8'h00 || rb_data !== 8'h00) bad = 1;
    end
    check("R1", "all regs zero", 16'(bad), 16'h0);
    check("R1", "x_ptr", x_ptr, 16'h0);
    check("R1", "y_ptr", y_ptr, 16'h0);
    check("R1", "pm_addr", pm_addr, 16'h0);
  endtask

  task automatic t_alu();
    @(negedge clk);
    alu_we = 1; alu_widx = 5; alu_wdata = 8'hA5; ra_idx = 5; #1;
    check("R2", "read before edge sees old", 16'(ra_data), 16'h00);
    step();
    rb_idx = 5; #1;
    check("R3", "port A after write", 16'(ra_data), 16'hA5);
    check("R2", "port B after write", 16'(rb_data), 16'hA5);
    @(negedge clk); alu_we = 1; alu_widx = 26; alu_wdata = 8'h34; step();
    @(negedge clk); alu_we = 1; alu_widx = 27; alu_wdata = 8'h12; step();
    check("R4", "x_ptr from reg27:26", x_ptr, 16'h1234);
  endtask

  task automatic t_ptr();
    @(negedge clk);
    ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'hBEEF; step();
    check("R5", "y_ptr written", y_ptr, 16'hBEEF);
    ra_idx = 28; rb_idx = 29; #1;
    check("R4", "reg28 low byte", 16'(ra_data), 16'h00EF);
    check("R4", "reg29 high byte", 16'(rb_data), 16'h00BE);
    @(negedge clk);
    ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'h7777; step();
    check("R5", "sel 3 leaves x", x_ptr, 16'h1234);
    check("R5", "sel 3 leaves y", y_ptr, 16'hBEEF);
    check("R5", "sel 3 leaves z", z_ptr, 16'h0000);
  endtask

  task automatic t_prio();
    @(negedge clk);
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h5566;
    alu_we = 1; alu_widx = 30; alu_wdata = 8'hFF; step();
    check("R6", "z after clash", z_ptr, 16'h5566);
    check("R4", "pm_addr follows z", pm_addr, 16'h5566);
  endtask

  task automatic t_ds_reg();
    @(negedge clk);
    ds_valid = 1; ds_we = 1; ds_addr = 16'h0007; ds_wdata = 8'h3C; #1;
    check("R7", "reg target ready", 16'(ds_ready), 16'h1);
    check("R10", "no ext strobes on reg write", {13'h0, io_valid, sram_rd, sram_wr}, 16'h0);
    step();
    ra_idx = 7; #1;
    check("R7", "ds write seen on port A", 16'(ra_data), 16'h3C);
    @(negedge clk);
    ds_valid = 1; ds_we = 0; ds_addr = 16'h001F; #1;
    check("R7", "ds read of reg31", 16'(ds_rdata), 16'h0055);
    step();
  endtask

  task automatic t_io();
    @(negedge clk);
    io_ready = 1; io_rdata = 8'h9A;
    ds_valid = 1; ds_we = 0; ds_addr = 16'h0020; #1;
    check("R8", "io_valid at 0x20", 16'(io_valid), 16'h1);
    check("R8", "io_addr at 0x20", 16'(io_addr), 16'h0);
    check("R8", "read data from io", 16'(ds_rdata), 16'h009A);
    check("R10", "no sram at 0x20", {14'h0, sram_rd, sram_wr}, 16'h0);
    ds_we = 1; ds_addr = 16'h005F; ds_wdata = 8'h44; io_ready = 0; #1;
    check("R8", "io_addr at 0x5F", 16'(io_addr), 16'h003F);
    check("R8", "io write strobe and data", {7'h0, io_we, io_wdata}, 16'h0144);
    check("R8", "back-pressure from io", 16'(ds_ready), 16'h0);
    io_ready = 1;
    step();
    ra_idx = 31; #1;
    check("R8", "io write leaves reg31", 16'(ra_data), 16'h0055);
  endtask

  task automatic t_sram();
    @(negedge clk);
    sram_ready = 1; sram_rdata = 8'hC3;
    ds_valid = 1; ds_we = 0; ds_addr = 16'h0060; #1;
    check("R9", "sram strobes read", {14'h0, sram_rd, sram_wr}, 16'h2);
    check("R9", "sram addr", sram_addr, 16'h0060);
    check("R9", "sram read data", 16'(ds_rdata), 16'h00C3);
    check("R10", "no io at 0x60", 16'(io_valid), 16'h0);
    ds_we = 1; ds_addr = 16'h1234; ds_wdata = 8'h81; sram_ready = 0; #1;
    check("R9", "sram strobes write", {14'h0, sram_rd, sram_wr}, 16'h1);
    check("R9", "sram write data", 16'(sram_wdata), 16'h0081);
    check("R9", "back-pressure from sram", 16'(ds_ready), 16'h0);
    sram_ready = 1;
    step();
    ds_valid = 0; ds_addr = 16'h0060; #1;
    check("R10", "idle: no strobes", {13'h0, io_valid, sram_rd, sram_wr}, 16'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errs++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_ptr();
    t_prio();
    t_ds_reg();
    t_io();
    t_sram();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule